// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches at fetch time. It holds three tables of 2-bit saturating counters. The first is a global component: its index is the shared outcome history XOR-ed with word-address bits of the branch PC. The second is a two-level local component: a small table of per-branch history registers is selected by the PC, and that history, XOR-ed with PC bits, picks a counter in a second table. The third is a chooser table, indexed by the PC, which records for each branch which component has been right more often. The chooser's verdict selects the final direction.

A fetch lookup is combinational. The caller presents a PC and, in the same cycle, gets the final direction, both component directions and the next fetch PC. The next fetch PC is the sequential address on a not-taken guess, or the last recorded target for that branch on a taken guess. The caller keeps the two component directions with the branch. When the branch resolves, it sends them back together with the PC, the real outcome and the real target, and the tables, histories and target entry are then trained.

Both streams use valid/ready. The block never applies back-pressure: `fq_ready` and `rs_ready` are always high, so a lookup is served in any cycle where `fq_valid` is high and a resolve is consumed in any cycle where `rs_valid` is high. The fetch response carries no ready signal. It is valid in the same cycle as its request, and the caller must take it then.

Top module: `tp_tourn_pred`

## Requirements
- R1: Every counter holds 0..3. A resolve with a taken outcome raises the counter it trains by one, stopping at 3. A not-taken outcome lowers it by one, stopping at 0.
- R2: A counter value of 2 or 3 means taken and 0 or 1 means not-taken. `fp_gdir` and `fp_ldir` report this reading for the two component counters selected by `fq_pc`.
- R3: The global counter index is `ghr ^ pc[11:2]`, where `ghr` is a 10-bit history. Each accepted resolve shifts `ghr` left and puts `rs_taken` into bit 0. The global counter is trained at the index formed from the history before that shift.
- R4: The local component has 64 history registers of 10 bits each, selected by `pc[7:2]`. Its counter index is `hist ^ pc[11:2]`. A resolve trains that counter and then shifts `rs_taken` into bit 0 of the selected history.
- R5: A 1024-entry chooser is indexed by `pc[11:2]`. A value of 2 or more makes `fp_taken` follow the global direction, and a lower value makes it follow the local direction. On a resolve, the chooser counts up when only `rs_gdir` matched the outcome, counts down when only `rs_ldir` matched, and is left unchanged when both or neither matched.
- R6: `fp_next_pc` equals `fq_pc + 4` when `fp_taken` is 0. Otherwise it equals the 64-entry target table entry selected by `fq_pc[7:2]`. A resolve with `rs_taken` = 1 writes `rs_target` into the entry selected by `rs_pc[7:2]`.
- R7: After reset every counter is 1, every history and `ghr` are 0, and every target is 0. Until the first resolve, lookups therefore predict not-taken with a next PC of `fq_pc + 4`.
- R8: When a lookup and a resolve fall in the same cycle, the lookup sees the state from before that resolve. The update becomes visible from the next cycle onward.
- R9: `fq_ready` and `rs_ready` are always 1, and `fp_valid` equals `fq_valid`. A cycle with `rs_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fq_valid | input | 1 | Lookup request valid |
| fq_ready | output | 1 | Lookup accepted (always 1) |
| fq_pc | input | 32 | PC of the branch being fetched |
| fp_valid | output | 1 | Lookup response valid, same cycle as request |
| fp_taken | output | 1 | Final direction chosen by the chooser |
| fp_next_pc | output | 32 | Next fetch address |
| fp_gdir | output | 1 | Global component direction |
| fp_ldir | output | 1 | Local component direction |
| rs_valid | input | 1 | Resolve update valid |
| rs_ready | output | 1 | Resolve accepted (always 1) |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | 32 | Actual target address |
| rs_gdir | input | 1 | Global direction given at fetch |
| rs_ldir | input | 1 | Local direction given at fetch |

## Verification
A lookup and a training update can land on the same branch in the same cycle. That includes the same counter, the same local history and the same target entry, while the shared history is also shifting. The bench sends the same PC on both streams in about a quarter of cycles and checks that the lookup reflects only the state before the edge. A behavioural model updated after each comparison judges the result. Biased, looping and random branches drive the counters into saturation. Mismatched component guesses train the chooser in both directions.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RST = 2'd1;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_dir(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output ctr_t          rd_val,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_up
);
  ctr_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RST;
    end else if (we) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  assign rd_val = mem[rd_idx];

  p_sat_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_up && mem[wr_idx] == 2'd3) |=> mem[$past(wr_idx)] == 2'd3);

  p_sat_bot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_up && mem[wr_idx] == 2'd0) |=> mem[$past(wr_idx)] == 2'd0);

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_up && mem[wr_idx] != 2'd3) |=>
      mem[$past(wr_idx)] == 2'($past(mem[wr_idx]) + 2'd1));
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int DEPTH = 64,
  parameter int HW    = 10,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_idx,
  output logic [HW-1:0] a_hist,
  input  logic [IW-1:0] b_idx,
  output logic [HW-1:0] b_hist,
  input  logic          we,
  input  logic          wr_bit
);
  logic [HW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[b_idx] <= {mem[b_idx][HW-2:0], wr_bit};
    end
  end

  assign a_hist = mem[a_idx];
  assign b_hist = mem[b_idx];

  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(b_idx)][0] == $past(wr_bit));
endmodule

// File: rtl/tp_tgt_table.sv
module tp_tgt_table #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_tgt,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_tgt
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_tgt;
    end
  end

  assign rd_tgt = mem[rd_idx];

  p_tgt_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wr_idx)] == $past(wr_tgt));
endmodule

// File: rtl/tp_tourn_pred.sv
module tp_tourn_pred
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CTR_DEPTH = 1024,
  parameter int LH_DEPTH  = 64,
  parameter int TGT_DEPTH = 64,
  localparam int CIW = $clog2(CTR_DEPTH),
  localparam int LIW = $clog2(LH_DEPTH),
  localparam int TIW = $clog2(TGT_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fq_valid,
  output logic            fq_ready,
  input  logic [PC_W-1:0] fq_pc,
  output logic            fp_valid,
  output logic            fp_taken,
  output logic [PC_W-1:0] fp_next_pc,
  output logic            fp_gdir,
  output logic            fp_ldir,
  input  logic            rs_valid,
  output logic            rs_ready,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_gdir,
  input  logic            rs_ldir
);
  logic [CIW-1:0] ghr;
  logic [CIW-1:0] f_base, r_base;
  logic [CIW-1:0] f_lhist, r_lhist;
  ctr_t           f_gctr, f_lctr, f_chctr;
  logic [PC_W-1:0] f_tgt;
  logic           r_we, r_ch_we, r_tgt_we;
  logic           unused_pc_bits;

  assign f_base = fq_pc[CIW+1:2];
  assign r_base = rs_pc[CIW+1:2];
  assign unused_pc_bits = ^{rs_pc[PC_W-1:CIW+2], rs_pc[1:0]};

  assign r_we     = rs_valid;
  assign r_ch_we  = rs_valid && (rs_gdir != rs_ldir);
  assign r_tgt_we = rs_valid && rs_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ghr <= '0;
    else if (r_we) ghr <= {ghr[CIW-2:0], rs_taken};
  end

  tp_ctr_table #(.DEPTH(CTR_DEPTH)) u_glob (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr ^ f_base), .rd_val(f_gctr),
    .we(r_we), .wr_idx(ghr ^ r_base), .wr_up(rs_taken)
  );

  tp_hist_table #(.DEPTH(LH_DEPTH), .HW(CIW)) u_lhist (
    .clk(clk), .rst_n(rst_n),
    .a_idx(fq_pc[LIW+1:2]), .a_hist(f_lhist),
    .b_idx(rs_pc[LIW+1:2]), .b_hist(r_lhist),
    .we(r_we), .wr_bit(rs_taken)
  );

  tp_ctr_table #(.DEPTH(CTR_DEPTH)) u_loc (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_lhist ^ f_base), .rd_val(f_lctr),
    .we(r_we), .wr_idx(r_lhist ^ r_base), .wr_up(rs_taken)
  );

  tp_ctr_table #(.DEPTH(CTR_DEPTH)) u_choose (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_base), .rd_val(f_chctr),
    .we(r_ch_we), .wr_idx(r_base), .wr_up(rs_gdir == rs_taken)
  );

  tp_tgt_table #(.DEPTH(TGT_DEPTH), .W(PC_W)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(fq_pc[TIW+1:2]), .rd_tgt(f_tgt),
    .we(r_tgt_we), .wr_idx(rs_pc[TIW+1:2]), .wr_tgt(rs_target)
  );

  assign fp_gdir    = ctr_dir(f_gctr);
  assign fp_ldir    = ctr_dir(f_lctr);
  assign fp_taken   = ctr_dir(f_chctr) ? fp_gdir : fp_ldir;
  assign fp_next_pc = fp_taken ? f_tgt : fq_pc + PC_W'(4);
  assign fp_valid   = fq_valid;
  assign fq_ready   = 1'b1;
  assign rs_ready   = 1'b1;

  p_ghr_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> ghr[0] == $past(rs_taken));

  p_ghr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ghr));
endmodule

// File: tb/tp_tourn_pred_tb.sv
`timescale 1ns/1ps
module tp_tourn_pred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fq_valid = 1'b0, fq_ready;
  logic [31:0] fq_pc = '0;
  logic        fp_valid, fp_taken, fp_gdir, fp_ldir;
  logic [31:0] fp_next_pc;
  logic        rs_valid = 1'b0, rs_ready;
  logic [31:0] rs_pc = '0, rs_target = '0;
  logic        rs_taken = 1'b0, rs_gdir = 1'b0, rs_ldir = 1'b0;

  always #2.5 clk = ~clk;

  tp_tourn_pred dut_i (
    .clk(clk), .rst_n(rst_n),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_pc(fq_pc),
    .fp_valid(fp_valid), .fp_taken(fp_taken), .fp_next_pc(fp_next_pc),
    .fp_gdir(fp_gdir), .fp_ldir(fp_ldir),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_target(rs_target),
    .rs_gdir(rs_gdir), .rs_ldir(rs_ldir)
  );

  // behavioural reference state
  int gm [1024];
  int lm [1024];
  int cm [1024];
  int lh [64];
  int tg [64];
  int ghr;
  int errors = 0;
  int checks = 0;
  bit done = 0;
  int loopcnt [8];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int base_of(logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  function automatic bit gdir_of(logic [31:0] pc);
    return gm[(ghr ^ base_of(pc)) & 1023] >= 2;
  endfunction

  function automatic bit ldir_of(logic [31:0] pc);
    return lm[(lh[pc[7:2]] ^ base_of(pc)) & 1023] >= 2;
  endfunction

  function automatic int step(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic compare_outputs(bit collide);
    bit eg, el, et;
    logic [31:0] en;
    string tag;
    eg = gdir_of(fq_pc);
    el = ldir_of(fq_pc);
    et = (cm[base_of(fq_pc)] >= 2) ? eg : el;
    en = et ? 32'(tg[fq_pc[7:2]]) : fq_pc + 32'd4;
    tag = collide ? "R8 same-cycle" : "steady";
    chk({"R9 fp_valid ", tag}, {31'd0, fp_valid}, {31'd0, fq_valid});
    chk({"R9 ready ", tag}, {30'd0, fq_ready, rs_ready}, 32'd3);
    chk({"R1 R2 R3 gdir ", tag}, {31'd0, fp_gdir}, {31'd0, eg});
    chk({"R1 R2 R4 ldir ", tag}, {31'd0, fp_ldir}, {31'd0, el});
    chk({"R5 taken ", tag}, {31'd0, fp_taken}, {31'd0, et});
    chk({"R6 next_pc ", tag}, fp_next_pc, en);
  endtask

  task automatic model_update();
    int b, gi, li, s;
    if (!rs_valid) return;
    b  = base_of(rs_pc);
    gi = (ghr ^ b) & 1023;
    li = (lh[rs_pc[7:2]] ^ b) & 1023;
    gm[gi] = step(gm[gi], rs_taken);
    lm[li] = step(lm[li], rs_taken);
    if (rs_gdir != rs_ldir) cm[b] = step(cm[b], rs_gdir == rs_taken);
    s = rs_pc[7:2];
    lh[s] = ((lh[s] << 1) | int'(rs_taken)) & 1023;
    ghr = ((ghr << 1) | int'(rs_taken)) & 1023;
    if (rs_taken) tg[s] = int'(rs_target);
  endtask

  function automatic logic [31:0] pool_pc(int k);
    return 32'h0000_4000 + 32'(k) * 32'h0000_0104;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin gm[i] = 1; lm[i] = 1; cm[i] = 1; end
    for (int i = 0; i < 64; i++) begin lh[i] = 0; tg[i] = 0; end
    for (int i = 0; i < 8; i++) loopcnt[i] = 0;
    ghr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: state after reset, before any training
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fq_valid = 1'b1;
      fq_pc = {20'd0, 10'($urandom), 2'b00};
      #1;
      chk("R7 reset taken", {31'd0, fp_taken}, 32'd0);
      chk("R7 reset next_pc", fp_next_pc, fq_pc + 32'd4);
    end

    // R9: idle resolve channel changes nothing observable
    @(negedge clk);
    fq_pc = pool_pc(0);
    #1;
    compare_outputs(0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      int k;
      bit collide;
      @(negedge clk);
      k = $urandom_range(0, 7);
      rs_valid = ($urandom_range(0, 3) != 0);
      rs_pc = (k == 7) ? {20'd0, 10'($urandom), 2'b00} : pool_pc(k);
      case (k)
        0: rs_taken = 1'b1;
        1: rs_taken = 1'b0;
        2: begin
             loopcnt[2] = (loopcnt[2] + 1) % 4;
             rs_taken = (loopcnt[2] != 0);
           end
        3: rs_taken = ($urandom_range(0, 9) != 0);
        default: rs_taken = 1'($urandom);
      endcase
      rs_target = 32'h0008_0000 + 32'(k) * 32'h40 + 32'($urandom_range(0, 3)) * 4;
      if ($urandom_range(0, 2) == 0) begin
        rs_gdir = 1'($urandom);
        rs_ldir = 1'($urandom);
      end else begin
        rs_gdir = gdir_of(rs_pc);
        rs_ldir = ldir_of(rs_pc);
      end
      collide = ($urandom_range(0, 3) == 0);
      fq_valid = ($urandom_range(0, 7) != 0);
      fq_pc = collide ? rs_pc : pool_pc($urandom_range(0, 6));
      #1;
      compare_outputs(collide && rs_valid);
      model_update();
    end

    @(negedge clk);
    rs_valid = 1'b0;
    fq_pc = pool_pc(0);
    #1;
    compare_outputs(0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule